// File: doc/BRIEF.md
# ARX 64-bit Block Encryption Core

This core encrypts one 64-bit block under a 128-bit key with a generalized Feistel network. The network holds eight bytes and mixes them only with addition modulo 256, fixed 8-bit left rotations and XOR. A block and its key are taken over a valid/ready handshake. The core first mixes four whitening bytes into the block. It then runs 32 rounds, one per clock. Each round uses four subkey bytes that are made on the fly from the held key and a 7-bit LFSR constant sequence. The last round also applies the closing whitening. The 64-bit ciphertext is presented with a one-cycle done pulse.

While a block is in flight, the core shows the current round number and the eight state bytes on observation outputs. These outputs are meant for debug and for fault-injection studies. The ciphertext register holds its value until the next block completes.

Top module: `arx64_encrypt_core`

## Requirements
- R1: Reset is synchronous and active low. After reset: `in_ready`=1, `done`=0, `ct_out`=0, `round_idx`=0, `state_bytes`=0.
- R2: A block is accepted on a rising edge where `in_valid`=1 and `in_ready`=1. `in_ready` is 0 from the accept edge until the result edge. `in_valid` asserted while busy has no effect on the running block or on its ciphertext.
- R3: `done` is 1 for exactly one cycle, after the 32nd rising edge that follows the accept edge. `in_ready` returns to 1 at that same edge, so a back-to-back block can be accepted on the next edge.
- R4: `ct_out` equals the cipher output for the accepted key and plaintext. It keeps that value until the next block completes.
- R5: `round_idx` shows k after the accept edge plus k further edges (k = 0..31). It reads 0 while idle.
- R6: While busy, `state_bytes` holds the input of round `round_idx`. After completion it holds the output of the last round. State byte j sits at bits [8j+7:8j].
- R7: The first state is formed from the plaintext (byte j = `pt_in`[8j+7:8j]) and key bytes (byte b = `key_in`[8b+7:8b]) as follows. Odd bytes pass unchanged. Byte0 = P0 + K12, byte2 = P2 ^ K13, byte4 = P4 + K14, byte6 = P6 ^ K15.
- R8: The ciphertext is formed from the last-round output X as follows. Odd bytes pass unchanged. C0 = X0 + K0, C2 = X2 ^ K1, C4 = X4 + K2, C6 = X6 ^ K3.
- R9: Round r uses G(x) = rotl1^rotl2^rotl7 and H(x) = rotl3^rotl4^rotl6, with four terms:
  - t0 = X1 + (H(X0) ^ S[4r])
  - t1 = X3 ^ (G(X2) + S[4r+1])
  - t2 = X5 + (H(X4) ^ S[4r+2])
  - t3 = X7 ^ (G(X6) + S[4r+3])

  Rounds 0..30 output X0=t3, X2=t0, X4=t1, X6=t2, and each odd byte X(2g+1) takes the old X(2g). Round 31 writes t0..t3 into X1, X3, X5, X7 and leaves the even bytes unchanged.
- R10: Subkeys are built as follows. The constants are d[n] = s[n+6..n] with s0..s6 = 0,1,0,1,1,0,1 (d[0] = 0x5A) and s[n] = s[n-4] ^ s[n-7]. For a = 0..7 and b = 0..7: S[16a+b] = K[(b-a) mod 8] + d[16a+b] and S[16a+b+8] = K[8+((b-a) mod 8)] + d[16a+b+8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Key and plaintext are valid |
| in_ready | output | 1 | Core is idle and can accept a block |
| key_in | input | 128 | Master key, byte b at [8b+7:8b] |
| pt_in | input | 64 | Plaintext, byte j at [8j+7:8j] |
| ct_out | output | 64 | Ciphertext, held until the next result |
| done | output | 1 | One-cycle pulse when `ct_out` is updated |
| round_idx | output | 5 | Current round number while busy, 0 while idle |
| state_bytes | output | 64 | Observation of the round state bytes |

## Verification
The core is exercised with all-zero and all-one keys and blocks, which show carry and rotation faults that cancel only on uniform data. It also runs a key of ascending byte values with a mixed plaintext, which tells apart key-byte selection errors in the subkey and whitening paths. Generator-made blocks are run back to back to separate accept timing from done timing. One block is driven with a competing request while busy, which shows whether a busy core can be restarted. The state is compared every cycle against a reference model, so an error is pinned to the round where it first appears.

// File: rtl/arx64_pkg.sv
// Package: shared constants and ARX helper functions for the 64-bit cipher core.
// Assumes a byte-oriented state of BLK_BYTES bytes and a 7-bit constant LFSR.
package arx64_pkg;
    localparam int unsigned BLK_BYTES    = 8;
    localparam int unsigned KEY_BYTES    = 16;
    localparam int unsigned N_ROUNDS     = 32;
    localparam int unsigned SK_PER_ROUND = 4;
    localparam int unsigned RND_W        = $clog2(N_ROUNDS);
    localparam int unsigned LFSR_W       = 7;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 7'h5A;

    // Mixing function G: rotations by 1, 2 and 7 combined by XOR.
    function automatic logic [7:0] mix_g(input logic [7:0] v);
        return {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[0], v[7:1]};
    endfunction

    // Mixing function H: rotations by 3, 4 and 6 combined by XOR.
    function automatic logic [7:0] mix_h(input logic [7:0] v);
        return {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ {v[1:0], v[7:2]};
    endfunction

    // One step of the constant LFSR: new top bit is bit3 ^ bit0, shift right.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] d);
        return {d[3] ^ d[0], d[LFSR_W-1:1]};
    endfunction
endpackage

// File: rtl/arx64_whiten.sv
// Whitening stage: mixes four key bytes into the even state bytes.
// Bytes 0 and 4 take a modular add, bytes 2 and 6 take an XOR; odd bytes pass.
// Used both before the first round and after the last round.
module arx64_whiten
    import arx64_pkg::*;
(
    input  logic [8*BLK_BYTES-1:0]   data_in,
    input  logic [8*(BLK_BYTES/2)-1:0] wk,
    output logic [8*BLK_BYTES-1:0]   data_out
);
    for (genvar g = 0; g < BLK_BYTES/2; g++) begin : g_pair
        // Even byte: add for even pair index, XOR for odd pair index.
        if (g % 2 == 0) begin : g_add
            assign data_out[16*g +: 8] = data_in[16*g +: 8] + wk[8*g +: 8];
        end else begin : g_xor
            assign data_out[16*g +: 8] = data_in[16*g +: 8] ^ wk[8*g +: 8];
        end
        // Odd byte passes unchanged.
        assign data_out[16*g+8 +: 8] = data_in[16*g+8 +: 8];
    end
endmodule

// File: rtl/arx64_subkey_gen.sv
// Subkey generator: produces the four subkey bytes of the current round from
// the held master key and an LFSR that carries the constant of subkey 4*round.
// Assumes round advances by exactly one per advance pulse after load.
module arx64_subkey_gen
    import arx64_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic                       advance,
    input  logic [8*KEY_BYTES-1:0]     key,
    input  logic [RND_W-1:0]           rnd,
    output logic [8*SK_PER_ROUND-1:0]  sk
);
    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] dchain [0:SK_PER_ROUND];
    logic [2:0]        blk;

    assign dchain[0] = lfsr_q;
    assign blk       = rnd[RND_W-1:2];

    for (genvar k = 0; k < SK_PER_ROUND; k++) begin : g_sk
        localparam logic [1:0] KK = k;
        logic [3:0] j;
        logic [2:0] rot;
        logic [3:0] idx;
        assign dchain[k+1] = lfsr_step(dchain[k]);
        assign j   = {rnd[1:0], KK};
        assign rot = j[2:0] - blk;
        assign idx = {j[3], rot};
        assign sk[8*k +: 8] = key[{idx, 3'b000} +: 8] + {1'b0, dchain[k]};
    end

    // Constant register: seed on load, jump four steps per round.
    always_ff @(posedge clk) begin
        if (!rst_n)       lfsr_q <= LFSR_SEED;
        else if (load)    lfsr_q <= LFSR_SEED;
        else if (advance) lfsr_q <= dchain[SK_PER_ROUND];
    end

    p_lfsr_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
    p_seed_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> lfsr_q == LFSR_SEED);
endmodule

// File: rtl/arx64_round.sv
// Round datapath: one generalized Feistel round on eight bytes.
// Four ARX terms update the odd bytes; the byte rotation is skipped when last=1.
module arx64_round
    import arx64_pkg::*;
(
    input  logic [8*BLK_BYTES-1:0]    state_in,
    input  logic [8*SK_PER_ROUND-1:0] sk,
    input  logic                      last,
    output logic [8*BLK_BYTES-1:0]    state_out
);
    logic [7:0] t [0:BLK_BYTES/2-1];

    for (genvar g = 0; g < BLK_BYTES/2; g++) begin : g_term
        localparam int NXT = (2*g + 2) % BLK_BYTES;
        // ARX term for pair g: H with add for even g, G with xor for odd g.
        if (g % 2 == 0) begin : g_h
            assign t[g] = state_in[16*g+8 +: 8] + (mix_h(state_in[16*g +: 8]) ^ sk[8*g +: 8]);
        end else begin : g_g
            assign t[g] = state_in[16*g+8 +: 8] ^ (mix_g(state_in[16*g +: 8]) + sk[8*g +: 8]);
        end
        // Byte placement: rotate the state except in the final round.
        assign state_out[8*NXT +: 8]   = last ? state_in[8*NXT +: 8] : t[g];
        assign state_out[16*g+8 +: 8]  = last ? t[g] : state_in[16*g +: 8];
    end
endmodule

// File: rtl/arx64_encrypt_core.sv
// Top: iterative ARX block encryption, one round per clock.
// Accepts key/plaintext when idle, runs 32 rounds, applies the closing
// whitening in the last round cycle and pulses done for one cycle.
module arx64_encrypt_core
    import arx64_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [8*KEY_BYTES-1:0] key_in,
    input  logic [8*BLK_BYTES-1:0] pt_in,
    output logic [8*BLK_BYTES-1:0] ct_out,
    output logic                   done,
    output logic [RND_W-1:0]       round_idx,
    output logic [8*BLK_BYTES-1:0] state_bytes
);
    localparam logic [RND_W-1:0] LAST_RND = RND_W'(N_ROUNDS - 1);
    localparam int unsigned WK_W = 8 * (BLK_BYTES / 2);

    logic                    busy_q;
    logic [RND_W-1:0]        rnd_q;
    logic [8*BLK_BYTES-1:0]  state_q;
    logic [8*KEY_BYTES-1:0]  key_q;
    logic [8*BLK_BYTES-1:0]  ct_q;
    logic                    done_q;
    logic                    accept;
    logic                    last;
    logic [8*SK_PER_ROUND-1:0] sk;
    logic [8*BLK_BYTES-1:0]  init_state;
    logic [8*BLK_BYTES-1:0]  round_out;
    logic [8*BLK_BYTES-1:0]  final_out;

    assign accept      = in_valid && !busy_q;
    assign last        = rnd_q == LAST_RND;
    assign in_ready    = !busy_q;
    assign ct_out      = ct_q;
    assign done        = done_q;
    assign round_idx   = rnd_q;
    assign state_bytes = state_q;

    arx64_whiten u_init (
        .data_in  (pt_in),
        .wk       (key_in[8*KEY_BYTES-1 -: WK_W]),
        .data_out (init_state)
    );

    arx64_subkey_gen u_skgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .advance (busy_q && !last),
        .key     (key_q),
        .rnd     (rnd_q),
        .sk      (sk)
    );

    arx64_round u_round (
        .state_in  (state_q),
        .sk        (sk),
        .last      (last),
        .state_out (round_out)
    );

    arx64_whiten u_final (
        .data_in  (round_out),
        .wk       (key_q[WK_W-1:0]),
        .data_out (final_out)
    );

    // Control and state: accept when idle, step rounds, publish result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            rnd_q   <= '0;
            state_q <= '0;
            key_q   <= '0;
            ct_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                key_q   <= key_in;
                state_q <= init_state;
                rnd_q   <= '0;
                busy_q  <= 1'b1;
            end else if (busy_q) begin
                state_q <= round_out;
                if (last) begin
                    busy_q <= 1'b0;
                    rnd_q  <= '0;
                    ct_q   <= final_out;
                    done_q <= 1'b1;
                end else begin
                    rnd_q <= rnd_q + 1'b1;
                end
            end
        end
    end

    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy_q) && $past(rnd_q) == LAST_RND);
    p_round_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && !last |=> busy_q && rnd_q == $past(rnd_q) + 1'b1);
    p_idle_round_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> rnd_q == '0);
    p_ct_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && last) |=> $stable(ct_q));
    p_key_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(key_q));
endmodule

// File: tb/arx64_encrypt_core_tb.sv
// Bench: behavioural reference model computed per block, compared every clock.
module arx64_encrypt_core_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] key_in = '0;
    logic [63:0]  pt_in = '0;
    logic [63:0]  ct_out;
    logic         done;
    logic [4:0]   round_idx;
    logic [63:0]  state_bytes;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [63:0] exp_s [0:32];
    logic [63:0] exp_ct;
    bit          sbits [0:140];
    logic [63:0] lcg = 64'h9E3779B97F4A7C15;

    always #2.5 clk = ~clk;

    arx64_encrypt_core u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .key_in(key_in), .pt_in(pt_in), .ct_out(ct_out), .done(done),
        .round_idx(round_idx), .state_bytes(state_bytes)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
        logic [15:0] w;
        w = {v, v} << n;
        return w[15:8];
    endfunction

    function automatic logic [7:0] fg(input logic [7:0] v);
        return rotl(v, 1) ^ rotl(v, 2) ^ rotl(v, 7);
    endfunction

    function automatic logic [7:0] fh(input logic [7:0] v);
        return rotl(v, 3) ^ rotl(v, 4) ^ rotl(v, 6);
    endfunction

    function automatic logic [7:0] delta(input int n);
        logic [7:0] d = 0;
        for (int b = 0; b < 7; b++) d[b] = sbits[n+b];
        return d;
    endfunction

    // Reference model: fills exp_s[0..32] and exp_ct (R7, R9, R10, R8).
    task automatic model(input logic [127:0] k, input logic [63:0] p);
        logic [7:0] mk [0:15];
        logic [7:0] sk [0:127];
        logic [7:0] x [0:7];
        logic [7:0] t0, t1, t2, t3;
        for (int b = 0; b < 16; b++) mk[b] = k[8*b +: 8];
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
                sk[16*a+b]   = mk[(b-a+8)%8]     + delta(16*a+b);
                sk[16*a+b+8] = mk[(b-a+8)%8 + 8] + delta(16*a+b+8);
            end
        for (int j = 0; j < 8; j++) x[j] = p[8*j +: 8];
        x[0] = x[0] + mk[12];
        x[2] = x[2] ^ mk[13];
        x[4] = x[4] + mk[14];
        x[6] = x[6] ^ mk[15];
        for (int j = 0; j < 8; j++) exp_s[0][8*j +: 8] = x[j];
        for (int r = 0; r < 32; r++) begin
            t0 = x[1] + (fh(x[0]) ^ sk[4*r]);
            t1 = x[3] ^ (fg(x[2]) + sk[4*r+1]);
            t2 = x[5] + (fh(x[4]) ^ sk[4*r+2]);
            t3 = x[7] ^ (fg(x[6]) + sk[4*r+3]);
            if (r < 31) begin
                x[7] = x[6]; x[5] = x[4]; x[3] = x[2]; x[1] = x[0];
                x[0] = t3; x[2] = t0; x[4] = t1; x[6] = t2;
            end else begin
                x[1] = t0; x[3] = t1; x[5] = t2; x[7] = t3;
            end
            for (int j = 0; j < 8; j++) exp_s[r+1][8*j +: 8] = x[j];
        end
        x[0] = x[0] + mk[0];
        x[2] = x[2] ^ mk[1];
        x[4] = x[4] + mk[2];
        x[6] = x[6] ^ mk[3];
        for (int j = 0; j < 8; j++) exp_ct[8*j +: 8] = x[j];
    endtask

    function automatic logic [63:0] next_rand();
        lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
        return lcg;
    endfunction

    // Runs one block from the current negedge; optional busy-time competing request.
    task automatic run_block(input logic [127:0] k, input logic [63:0] p,
                             input bit idle_after, input bit spam);
        logic [63:0] ct_prev;
        model(k, p);
        ct_prev = ct_out;
        chk(in_ready == 1'b1, "R3 ready before accept", {63'd0, in_ready}, 64'd1);
        key_in = k; pt_in = p; in_valid = 1'b1;
        for (int c = 0; c <= 32; c++) begin
            @(negedge clk);
            if (c == 0) in_valid = 1'b0;
            if (spam && c >= 4 && c < 12) begin
                in_valid = 1'b1; key_in = ~k; pt_in = ~p;
            end else if (c >= 12) begin
                in_valid = 1'b0;
            end
            if (c < 32) begin
                chk(state_bytes == exp_s[c], c == 0 ? "R7 initial state" : "R9 round state", state_bytes, exp_s[c]);
                chk(round_idx == 5'(c), "R5 round index", 64'(round_idx), 64'(c));
                chk(in_ready == 1'b0, "R2 busy not ready", 64'(in_ready), 64'd0);
                chk(done == 1'b0, "R3 no early done", 64'(done), 64'd0);
                if (c > 0) chk(ct_out == ct_prev, "R4 ct held while busy", ct_out, ct_prev);
            end else begin
                chk(done == 1'b1, "R3 done pulse", 64'(done), 64'd1);
                chk(ct_out == exp_ct, "R4 R10 ciphertext", ct_out, exp_ct);
                chk(state_bytes == exp_s[32], "R6 last round output", state_bytes, exp_s[32]);
                chk({ct_out[63:56], ct_out[47:40], ct_out[31:24], ct_out[15:8]} ==
                    {exp_s[32][63:56], exp_s[32][47:40], exp_s[32][31:24], exp_s[32][15:8]},
                    "R8 odd bytes pass", ct_out, exp_s[32]);
                chk(in_ready == 1'b1, "R3 ready at result", 64'(in_ready), 64'd1);
                chk(round_idx == 5'd0, "R5 idle index", 64'(round_idx), 64'd0);
            end
        end
        in_valid = 1'b0;
        if (idle_after) begin
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                chk(done == 1'b0, "R3 done one cycle", 64'(done), 64'd0);
                chk(ct_out == exp_ct, "R4 ct held idle", ct_out, exp_ct);
                chk(state_bytes == exp_s[32], "R6 state held idle", state_bytes, exp_s[32]);
                chk(in_ready == 1'b1, "R2 idle ready", 64'(in_ready), 64'd1);
            end
        end
    endtask

    initial begin
        sbits[0] = 0; sbits[1] = 1; sbits[2] = 0; sbits[3] = 1;
        sbits[4] = 1; sbits[5] = 0; sbits[6] = 1;
        for (int n = 7; n <= 140; n++) sbits[n] = sbits[n-4] ^ sbits[n-7];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(in_ready == 1'b1, "R1 ready", 64'(in_ready), 64'd1);
        chk(done == 1'b0, "R1 done", 64'(done), 64'd0);
        chk(ct_out == 64'd0, "R1 ct", ct_out, 64'd0);
        chk(round_idx == 5'd0, "R1 round", 64'(round_idx), 64'd0);
        chk(state_bytes == 64'd0, "R1 state", state_bytes, 64'd0);
        run_block('0, '0, 1'b1, 1'b0);
        run_block('1, '1, 1'b1, 1'b0);
        run_block(128'h0f0e0d0c0b0a09080706050403020100, 64'h0123456789abcdef, 1'b1, 1'b0);
        // R2: competing request while busy must not disturb the block
        run_block(128'h00112233445566778899aabbccddeeff, 64'hfedcba9876543210, 1'b1, 1'b1);
        // R3 back-to-back blocks
        for (int i = 0; i < 4; i++) begin
            logic [127:0] kk;
            logic [63:0]  pp;
            kk = {next_rand(), next_rand()};
            pp = next_rand();
            run_block(kk, pp, i == 3, 1'b0);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R3 watchdog act=timeout exp=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule